// File: doc/BRIEF.md
# Alignment Marker Pulse Scheduler

This block times the alignment-marker requests on the transmit side of a Reed-Solomon FEC path. It stays silent until the reset sequencer raises `start_i`. In the cycle that follows the first sampled-high start, it issues a marker pulse. It then repeats that pulse at a fixed period for as long as start stays high. The width of the pulse and the spacing between pulses both depend on a line-rate mode code. The mode code is captured only while start is low.

After the second marker pulse has been fully issued, the block raises an acknowledge. The reset sequencer uses this acknowledge to move on towards transmit-ready. The block also produces the transmit data-valid strobe. That strobe follows an external cadence input and is suppressed in every cycle that carries a marker request.

Each mode has its own period, set by a design parameter. A period is counted in clock cycles from the first cycle of one pulse to the first cycle of the next, and it must be larger than the pulse width of its mode.

Top module: `am_pulse_sched`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) clears all counters. While it is applied, `am_pulse_o`, `tx_valid_o` and `am_ack_o` are low in the cycle that follows.
- R2: While `start_i` has been sampled low, `am_pulse_o`, `am_ack_o` and `tx_valid_o` are low in the next cycle, whatever the cadence input does.
- R3: The first marker pulse begins in the cycle immediately after the clock edge that first samples `start_i` high.
- R4: The marker pulse width in cycles is set by the 3-bit mode code: 0 gives 4, 1 gives 2, 2 gives 5, 3 gives 2, 4 gives 1 and 5 gives 2. Codes 6 and 7 behave as code 2.
- R5: Consecutive pulses begin exactly one mode period apart. The periods come from the parameters `PERIOD_M0` to `PERIOD_M5`, and codes 6 and 7 use `PERIOD_M2`. The default for every mode, including code 2, is 81920 cycles.
- R6: `am_ack_o` rises in the cycle right after the last cycle of the second marker pulse, and never earlier.
- R7: Once high, `am_ack_o` stays high while `start_i` stays high. One cycle after `start_i` is sampled low, the acknowledge and the marker pulses are low.
- R8: The mode code is captured only while `start_i` is low. A change of `mode_i` while start is high has no effect until the next start.
- R9: `tx_valid_o` is high exactly when the scheduler is running, `cadence_i` is high and no marker pulse is active. It is never high while `cadence_i` is low.
- R10: `tx_valid_o` is low in every cycle in which `am_pulse_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Marker-generation enable from the reset sequencer |
| mode_i | input | 3 | Line-rate mode code (see R4) |
| cadence_i | input | 1 | Permission to present data in this cycle |
| am_pulse_o | output | 1 | Alignment-marker request pulse |
| tx_valid_o | output | 1 | Paced transmit data-valid strobe |
| am_ack_o | output | 1 | Two markers have been issued |

## Verification
The hardest situation to reach from the ports is a mode change while the scheduler is running. This change must leave the pulse width and the period untouched, and only the next start may pick up the new mode. To reach it, the bench holds start high, changes `mode_i` halfway through the first period, and keeps checking the whole two-period pulse pattern against the old mode. It then drops start and restarts, and checks that the new mode takes effect. The mode periods are overridden to short values, so that every mode can be run through two full periods, with the acknowledge edge and a cadence pattern that drops every third cycle.

// File: rtl/am_sched_pkg.sv
package am_sched_pkg;

    typedef enum logic [2:0] {
        LM_25G  = 3'd0,
        LM_50G  = 3'd1,
        LM_100G = 3'd2,
        LM_WIDE = 3'd3,
        LM_FC32 = 3'd4,
        LM_FC64 = 3'd5,
        LM_RSV6 = 3'd6,
        LM_RSV7 = 3'd7
    } lane_mode_e;

    localparam int unsigned PW_W  = 3;
    localparam int unsigned PER_W = 32;

    // Timing chosen for the active mode
    typedef struct packed {
        logic [PER_W-1:0] period;
        logic [PW_W-1:0]  width;
    } am_cfg_t;

    function automatic logic [PW_W-1:0] pulse_width(lane_mode_e m);
        logic [PW_W-1:0] w;
        case (m)
            LM_25G:  w = 3'd4;
            LM_50G:  w = 3'd2;
            LM_WIDE: w = 3'd2;
            LM_FC32: w = 3'd1;
            LM_FC64: w = 3'd2;
            default: w = 3'd5;
        endcase
        return w;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/am_mode_latch.sv
module am_mode_latch
    import am_sched_pkg::*;
#(
    parameter int unsigned PERIOD_M0 = 81920,
    parameter int unsigned PERIOD_M1 = 81920,
    parameter int unsigned PERIOD_M2 = 81920,
    parameter int unsigned PERIOD_M3 = 81920,
    parameter int unsigned PERIOD_M4 = 81920,
    parameter int unsigned PERIOD_M5 = 81920
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       start_i,
    input  logic [2:0] mode_i,
    output am_cfg_t    cfg_o
);

    lane_mode_e mode_q;

    // Capture the mode only while the scheduler is idle
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q <= LM_100G;
        end else if (!start_i) begin
            mode_q <= lane_mode_e'(mode_i);
        end
    end

    always_comb begin
        cfg_o.width = pulse_width(mode_q);
        case (mode_q)
            LM_25G:  cfg_o.period = PER_W'(PERIOD_M0);
            LM_50G:  cfg_o.period = PER_W'(PERIOD_M1);
            LM_WIDE: cfg_o.period = PER_W'(PERIOD_M3);
            LM_FC32: cfg_o.period = PER_W'(PERIOD_M4);
            LM_FC64: cfg_o.period = PER_W'(PERIOD_M5);
            default: cfg_o.period = PER_W'(PERIOD_M2);
        endcase
    end

endmodule

// File: rtl/am_period_timer.sv
module am_period_timer
    import am_sched_pkg::*;
#(
    parameter int unsigned CNT_W = 17
) (
    input  logic    clk_i,
    input  logic    rst_i,
    input  logic    start_i,
    input  am_cfg_t cfg_i,
    output logic    run_o,
    output logic    am_o,
    output logic    ack_o
);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       done_q;
    logic [PER_W-1:0] cnt_ext;
    logic             wrap;
    logic             pulse_last;

    assign cnt_ext    = PER_W'(cnt_q);
    assign wrap       = (cnt_ext == (cfg_i.period - 1));
    assign pulse_last = (cnt_ext == PER_W'(cfg_i.width - 3'd1));

    always_ff @(posedge clk_i) begin
        if (rst_i || !start_i) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            done_q <= 2'd0;
        end else if (!run_q) begin
            run_q  <= 1'b1;
            cnt_q  <= '0;
        end else begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            if (pulse_last && done_q != 2'd2) begin
                done_q <= done_q + 2'd1;
            end
        end
    end

    assign run_o = run_q;
    assign am_o  = run_q && (cnt_ext < PER_W'(cfg_i.width));
    assign ack_o = (done_q == 2'd2);

endmodule

// File: rtl/am_valid_gate.sv
module am_valid_gate (
    input  logic run_i,
    input  logic am_i,
    input  logic cadence_i,
    output logic valid_o
);

    assign valid_o = run_i && cadence_i && !am_i;

endmodule

// File: rtl/am_pulse_sched.sv
module am_pulse_sched
    import am_sched_pkg::*;
#(
    parameter int unsigned PERIOD_M0 = 81920,
    parameter int unsigned PERIOD_M1 = 81920,
    parameter int unsigned PERIOD_M2 = 81920,
    parameter int unsigned PERIOD_M3 = 81920,
    parameter int unsigned PERIOD_M4 = 81920,
    parameter int unsigned PERIOD_M5 = 81920
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       start_i,
    input  logic [2:0] mode_i,
    input  logic       cadence_i,
    output logic       am_pulse_o,
    output logic       tx_valid_o,
    output logic       am_ack_o
);

    localparam int unsigned MAX_P = max2(max2(max2(PERIOD_M0, PERIOD_M1), max2(PERIOD_M2, PERIOD_M3)),
                                         max2(PERIOD_M4, PERIOD_M5));
    localparam int unsigned CNT_W = max2($clog2(MAX_P), 3);

    am_cfg_t cfg;
    logic    running;
    logic    am;

    am_mode_latch #(
        .PERIOD_M0(PERIOD_M0), .PERIOD_M1(PERIOD_M1), .PERIOD_M2(PERIOD_M2),
        .PERIOD_M3(PERIOD_M3), .PERIOD_M4(PERIOD_M4), .PERIOD_M5(PERIOD_M5)
    ) u_mode (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .mode_i  (mode_i),
        .cfg_o   (cfg)
    );

    am_period_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .cfg_i   (cfg),
        .run_o   (running),
        .am_o    (am),
        .ack_o   (am_ack_o)
    );

    am_valid_gate u_gate (
        .run_i     (running),
        .am_i      (am),
        .cadence_i (cadence_i),
        .valid_o   (tx_valid_o)
    );

    assign am_pulse_o = am;

endmodule

// File: rtl/am_pulse_sched_chk.sv
module am_pulse_sched_chk (
    input logic clk_i,
    input logic rst_i,
    input logic start_i,
    input logic cadence_i,
    input logic run_i,
    input logic am_pulse_o,
    input logic tx_valid_o,
    input logic am_ack_o
);

    logic [2:0] hi_len_q;
    logic [1:0] rises_q;
    logic       am_prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !start_i) begin
            hi_len_q  <= 3'd0;
            rises_q   <= 2'd0;
            am_prev_q <= 1'b0;
        end else begin
            am_prev_q <= am_pulse_o;
            hi_len_q  <= am_pulse_o ? ((hi_len_q == 3'd7) ? hi_len_q : hi_len_q + 3'd1) : 3'd0;
            if (am_pulse_o && !am_prev_q && rises_q != 2'd3) begin
                rises_q <= rises_q + 2'd1;
            end
        end
    end

    // R2
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !start_i |=> (!am_pulse_o && !am_ack_o && !tx_valid_o));

    // R3
    first_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !run_i) |=> am_pulse_o);

    // R4
    width_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        am_pulse_o |-> (hi_len_q < 3'd5));

    // R6
    ack_after_two_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        am_ack_o |-> (rises_q >= 2'd2));

    // R7
    ack_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (am_ack_o && start_i) |=> am_ack_o);

    // R9
    valid_cadence_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_valid_o |-> cadence_i);

    // R10
    no_valid_in_marker_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(am_pulse_o && tx_valid_o));

endmodule

bind am_pulse_sched am_pulse_sched_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .start_i    (start_i),
    .cadence_i  (cadence_i),
    .run_i      (running),
    .am_pulse_o (am_pulse_o),
    .tx_valid_o (tx_valid_o),
    .am_ack_o   (am_ack_o)
);

// File: tb/am_pulse_sched_tb.sv
module am_pulse_sched_tb;

    localparam int P0 = 20, P1 = 16, P2 = 40, P3 = 24, P4 = 12, P5 = 18;

    logic       clk = 1'b0;
    logic       rst_i;
    logic       start_i;
    logic [2:0] mode_i;
    logic       cadence_i;
    logic       am_pulse_o, tx_valid_o, am_ack_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    am_pulse_sched #(
        .PERIOD_M0(P0), .PERIOD_M1(P1), .PERIOD_M2(P2),
        .PERIOD_M3(P3), .PERIOD_M4(P4), .PERIOD_M5(P5)
    ) u_dut (
        .clk_i(clk), .rst_i(rst_i), .start_i(start_i), .mode_i(mode_i),
        .cadence_i(cadence_i), .am_pulse_o(am_pulse_o),
        .tx_valid_o(tx_valid_o), .am_ack_o(am_ack_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int outs();
        return {29'd0, am_pulse_o, tx_valid_o, am_ack_o};
    endfunction

    task automatic t_reset();
        rst_i = 1'b1; start_i = 1'b0; mode_i = 3'd2; cadence_i = 1'b1;
        repeat (3) @(negedge clk);
        #1 chk(outs() == 0, "R1 reset state", outs(), 0);
        rst_i = 1'b0;
    endtask

    // Runs one mode for two periods and checks pulse, ack and valid in every cycle
    task automatic t_mode(input logic [2:0] code, input int w, input int p, input bit chg);
        int bad_am = 0, bad_ack = 0, bad_v = 0;
        int a_act = 0, a_exp = 0, k_act = 0, k_exp = 0, v_act = 0, v_exp = 0;
        bit first_ok;
        @(negedge clk);
        start_i = 1'b0; mode_i = code; cadence_i = 1'b1;
        repeat (2) @(negedge clk);
        #1 chk(outs() == 0, "R2 idle before start", outs(), 0);
        start_i = 1'b1;
        first_ok = 1'b0;
        for (int i = 0; i < 2 * p + w + 3; i++) begin
            bit e_am, e_ack, e_v, cad;
            @(negedge clk);
            cad = (i % 3) != 0;
            cadence_i = cad;
            if (chg && i == p / 2) mode_i = 3'd4;
            #1;
            e_am  = (i % p) < w;
            e_ack = i >= p + w;
            e_v   = cad && !e_am;
            if (i == 0) first_ok = am_pulse_o;
            if (am_pulse_o !== e_am && bad_am == 0) begin bad_am = i + 1; a_act = am_pulse_o; a_exp = e_am; end
            if (am_ack_o !== e_ack && bad_ack == 0) begin bad_ack = i + 1; k_act = am_ack_o; k_exp = e_ack; end
            if (tx_valid_o !== e_v && bad_v == 0) begin bad_v = i + 1; v_act = tx_valid_o; v_exp = e_v; end
        end
        chk(first_ok, "R3 first pulse in cycle after start", first_ok, 1);
        chk(bad_am == 0, chg ? "R8 mode change ignored (pulse pattern)" : "R4/R5 pulse width and period", a_act, a_exp);
        chk(bad_ack == 0, "R6 ack after second pulse", k_act, k_exp);
        chk(bad_v == 0, "R9/R10 valid pacing", v_act, v_exp);
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        #1 chk(outs() == 0, "R7 ack and pulse cleared after start low", outs(), 0);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        mode_i = 3'd0; cadence_i = 1'b1; start_i = 1'b1;
        repeat (6) @(negedge clk);
        rst_i = 1'b1;
        @(negedge clk);
        #1 chk(outs() == 0, "R1 reset during run", outs(), 0);
        rst_i = 1'b0; start_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_mode(3'd0, 4, P0, 1'b0);
        t_mode(3'd1, 2, P1, 1'b0);
        t_mode(3'd2, 5, P2, 1'b0);
        t_mode(3'd3, 2, P3, 1'b0);
        t_mode(3'd4, 1, P4, 1'b0);
        t_mode(3'd5, 2, P5, 1'b0);
        t_mode(3'd7, 5, P2, 1'b0);
        t_mode(3'd0, 4, P0, 1'b1);
        t_mode(3'd5, 2, P5, 1'b0);
        t_reset_mid();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                chk(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule